// File: doc/BRIEF.md
# RF Synthesizer Tuning Sequencer

This block drives an external radio synthesizer that is programmed only through write-only serial registers. It accepts two commands. The first is a calibration that searches stored VCO settings for one that gives PLL lock. The second tunes the radio to a channel from 1 to 14. Each register write leaves the block as a 24-bit word on a valid/ready stream towards a serial shifter. A 4-bit register address sits in bits 23:20 and a 20-bit payload in bits 19:0. A simple read/write port reaches the lock-status register of the radio.

Calibration stays on channel 1. It steps through the VCO setting tables in order, and after each attempt it clears the status register and reads it back. If an attempt locks, the table after the one that locked is kept for later tuning. If none locks, the block falls back to a fixed autocal setting. Tuning writes, in this order: the synthesizer value, the divide ratio, the VCO setting, four mode-register words, and a transmit-gain word chosen by a per-channel power index.

Back-pressure on the output stream: a word is transferred on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid` stays high and `wr_word` keeps its value. The downstream side may hold `wr_ready` low for any length of time.

Top module: `rf_tune_seq`

## Requirements
- R1: Every output word is {address[3:0], value[19:0]}. The only addresses used are 0 (mode), 1 (synthesizer), 2 (divide ratio), 3 (VCO) and 7 (transmit gain).
- R2: Every attempt, whether calibration or tuning, starts with address 1 and then address 2. The synthesizer value is 0x47 for channels 1-2, 0x67 for 3-6, 0x57 for 7-10, 0x77 for 11-13 and 0x4F for channel 14. The divide ratio is 0xCCC for channel 14. For other channels it is 0x999, 0x99B, 0x998 or 0x99A, selected by (channel-1) mod 4 = 0, 1, 2 or 3.
- R3: The third word of each attempt goes to address 3 and carries 0x40000 ORed with the 16-bit VCO table value. The table column is (channel-1)/2.
- R4: In calibration, after each VCO word the block pulses `st_wr_en` for one cycle with `st_wdata` = 0x000F. In the next cycle it pulses `st_rd_en`. It samples `st_rdata` at the end of the cycle after the read pulse. Lock means `st_rdata[3:0]` reads zero.
- R5: Calibration tries tables 0 to 9 on channel 1, in order, and stops at the first one that locks. Later tuning uses table (lock index + 1).
- R6: If no table locks, the block writes 0x106847, 0x200999 and 0x346662 and then raises `autocal_active`. Later tuning then uses synthesizer value 0x6800 OR the channel's value from R2, and the fixed VCO value 0x6662.
- R7: Tuning writes, in order: the three words of R2/R3, then mode words 0x25F98, 0x25F9A, 0x25F94, 0x27FD4, then one gain word at address 7.
- R8: The gain word comes from a 19-entry table indexed by `cmd_pwr` (for example 0→0x0E313, 4→0x0EA93, 5→0x1F093, 18→0x3FFFF). No gain word is sent when `cmd_pwr` is 19 or higher.
- R9: A tune command is rejected in two cases: when `cmd_chan` is 0 or above 14, or when no calibration has finished yet. A rejected command raises `err` for exactly the one cycle after the command, sends no words and leaves `busy` low.
- R10: `busy` rises in the cycle after a command is accepted. `busy` falls, and `done` pulses for one cycle, right after the last transfer (or, for a locking calibration, after the lock check). Commands that arrive while `busy` is high are ignored.
- R11: While `wr_valid` is high and `wr_ready` is low, the word is held unchanged, and no word is dropped or repeated under any stall pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cal | input | 1 | Start calibration (single-cycle, takes priority) |
| cmd_tune | input | 1 | Start tuning to `cmd_chan` |
| cmd_chan | input | 4 | Channel number, 1 to 14 |
| cmd_pwr | input | 5 | Transmit power index for the tune |
| wr_valid | output | 1 | Register word available |
| wr_ready | input | 1 | Downstream shifter accepts the word |
| wr_word | output | 24 | Address and payload of the register write |
| st_wr_en | output | 1 | Write strobe to the lock-status register |
| st_wdata | output | 16 | Write data to the status register |
| st_rd_en | output | 1 | Read strobe to the status register |
| st_rdata | input | 16 | Status register data, valid the cycle after `st_rd_en` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |
| autocal_active | output | 1 | Last calibration fell back to autocal |

## Verification
The command is sampled on one clock edge, and `busy` (or `err`, for a rejected tune) is already valid at the falling edge that follows. The bench checks it exactly there. The bench drives all inputs 2 ns after a rising edge and samples at falling edges. At a falling edge it logs a transfer as soon as `valid && ready` holds, and the transfer completes on the next rising edge. The status model loads `st_rdata` in the read-pulse cycle, so the data is stable through the sampling edge one cycle later. `done` is checked in the cycle it rises and again one cycle later. Word counts are checked several idle cycles after completion, which shows that ignored or rejected commands added no writes.

// File: rtl/rts_pkg.sv
package rts_pkg;

  localparam int WORD_W = 24;
  localparam int ADDR_W = 4;
  localparam int VAL_W  = 20;

  typedef enum logic [3:0] {
    K_SYN, K_DIV, K_VCO, K_M0, K_M1, K_M2, K_M3, K_GAIN
  } step_t;

  localparam logic [ADDR_W-1:0] RA_MODE = 4'd0;
  localparam logic [ADDR_W-1:0] RA_SYN  = 4'd1;
  localparam logic [ADDR_W-1:0] RA_DIV  = 4'd2;
  localparam logic [ADDR_W-1:0] RA_VCO  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_GAIN = 4'd7;

  localparam logic [VAL_W-1:0] VCO_RSVD   = 20'h40000;
  localparam logic [15:0]      AUTO_VCO   = 16'h6662;
  localparam logic [15:0]      AUTO_SYN_HI = 16'h6800;
  localparam logic [15:0]      ST_ACK     = 16'h000F;
  localparam logic [15:0]      LOCK_MASK  = 16'h000F;

  // synthesizer byte shared by groups of neighbouring channels
  function automatic logic [7:0] std_synth(input logic [3:0] ch);
    if (ch <= 4'd2)       return 8'h47;
    else if (ch <= 4'd6)  return 8'h67;
    else if (ch <= 4'd10) return 8'h57;
    else if (ch <= 4'd13) return 8'h77;
    else                  return 8'h4F;
  endfunction

  function automatic logic [11:0] frac_div(input logic [3:0] ch);
    logic [3:0] cm1;
    cm1 = ch - 4'd1;
    if (ch == 4'd14) return 12'hCCC;
    case (cm1[1:0])
      2'd0: return 12'h999;
      2'd1: return 12'h99B;
      2'd2: return 12'h998;
      default: return 12'h99A;
    endcase
  endfunction

  // VCO tables: each column shifts along one common low-byte sequence
  function automatic logic [15:0] vco_entry(input logic [3:0] tbl, input logic [2:0] col);
    logic [4:0] pos;
    logic [7:0] lo;
    logic [7:0] hi;
    pos = 5'(tbl) + 5'd3 - {3'b000, col[2:1]};
    case (pos)
      5'd0:  lo = 8'h65;
      5'd1:  lo = 8'h55;
      5'd2:  lo = 8'h75;
      5'd3:  lo = 8'h4D;
      5'd4:  lo = 8'h6D;
      5'd5:  lo = 8'h5D;
      5'd6:  lo = 8'h7D;
      5'd7:  lo = 8'h43;
      5'd8:  lo = 8'h63;
      5'd9:  lo = 8'h53;
      5'd10: lo = 8'h73;
      5'd11: lo = 8'h4B;
      5'd12: lo = 8'h6B;
      default: lo = 8'h5B;
    endcase
    if (col == 3'd1)  hi = 8'h60;
    else if (col[0])  hi = 8'h64;
    else              hi = 8'h66;
    return {hi, lo};
  endfunction

  function automatic logic [VAL_W-1:0] tx_gain(input logic [4:0] idx);
    case (idx)
      5'd0:  return 20'h0E313;
      5'd1:  return 20'h0FB13;
      5'd2:  return 20'h0E093;
      5'd3:  return 20'h0F893;
      5'd4:  return 20'h0EA93;
      5'd5:  return 20'h1F093;
      5'd6:  return 20'h1F493;
      5'd7:  return 20'h1F693;
      5'd8:  return 20'h1F393;
      5'd9:  return 20'h1F35B;
      5'd10: return 20'h1E6DB;
      5'd11: return 20'h1FF3F;
      5'd12: return 20'h1FFFF;
      5'd13: return 20'h361D7;
      5'd14: return 20'h37FBF;
      5'd15: return 20'h3FF8B;
      5'd16: return 20'h3FF33;
      5'd17: return 20'h3FB3F;
      5'd18: return 20'h3FFFF;
      default: return 20'h00000;
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] mode_word(input step_t s);
    case (s)
      K_M0:    return 20'h25F98;
      K_M1:    return 20'h25F9A;
      K_M2:    return 20'h25F94;
      default: return 20'h27FD4;
    endcase
  endfunction

endpackage

// File: rtl/rts_word_gen.sv
module rts_word_gen
  import rts_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int TBL_W = 4,
  parameter int PWR_W = 5
) (
  input  step_t              step,
  input  logic [CH_W-1:0]    chan,
  input  logic [TBL_W-1:0]   tbl,
  input  logic               use_auto,
  input  logic [PWR_W-1:0]   pwr,
  output logic [WORD_W-1:0]  word
);

  logic [ADDR_W-1:0] addr;
  logic [VAL_W-1:0]  val;
  logic [CH_W-1:0]   cm1;
  logic [7:0]        syn8;
  logic [15:0]       vco16;

  assign cm1   = chan - CH_W'(1);
  assign syn8  = std_synth(4'(chan));
  assign vco16 = use_auto ? AUTO_VCO : vco_entry(4'(tbl), cm1[3:1]);

  always_comb begin
    addr = RA_MODE;
    val  = '0;
    case (step)
      K_SYN: begin
        addr = RA_SYN;
        val  = use_auto ? {4'h0, AUTO_SYN_HI | {8'h00, syn8}} : {12'h000, syn8};
      end
      K_DIV: begin
        addr = RA_DIV;
        val  = {8'h00, frac_div(4'(chan))};
      end
      K_VCO: begin
        addr = RA_VCO;
        val  = VCO_RSVD | {4'h0, vco16};
      end
      K_M0, K_M1, K_M2, K_M3: begin
        addr = RA_MODE;
        val  = mode_word(step);
      end
      K_GAIN: begin
        addr = RA_GAIN;
        val  = tx_gain(5'(pwr));
      end
      default: begin
        addr = RA_MODE;
        val  = '0;
      end
    endcase
  end

  assign word = {addr, val};

endmodule

// File: rtl/rts_fsm.sv
module rts_fsm
  import rts_pkg::*;
#(
  parameter int N_CFG    = 11,
  parameter int CHAN_MAX = 14,
  parameter int GAIN_N   = 19,
  parameter int CH_W     = 4,
  parameter int PWR_W    = 5,
  parameter int TBL_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cal,
  input  logic              cmd_tune,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [PWR_W-1:0]  cmd_pwr,
  input  logic              wr_ready,
  input  logic [15:0]       st_rdata,
  output step_t             step,
  output logic [CH_W-1:0]   chan,
  output logic [TBL_W-1:0]  tbl,
  output logic              use_auto,
  output logic [PWR_W-1:0]  pwr,
  output logic              wr_valid,
  output logic              st_wr_en,
  output logic              st_rd_en,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              autocal_active
);

  localparam int               N_TRY    = N_CFG - 1;
  localparam logic [TBL_W-1:0] LAST_TRY = TBL_W'(N_TRY - 1);

  typedef enum logic [2:0] {S_IDLE, S_EMIT, S_ACK, S_RD, S_CHK} st_t;

  st_t              state_q;
  step_t            step_q;
  logic             cal_mode_q, auto_sel_q, auto_q, cal_ok_q, done_q, err_q;
  logic [CH_W-1:0]  chan_q;
  logic [PWR_W-1:0] pwr_q;
  logic [TBL_W-1:0] tbl_q, cfg_q;
  logic             chan_ok, gain_ok, locked;

  assign chan_ok = (cmd_chan >= CH_W'(1)) && (cmd_chan <= CH_W'(CHAN_MAX));
  assign gain_ok = pwr_q < PWR_W'(GAIN_N);
  assign locked  = (st_rdata & LOCK_MASK) == 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      step_q     <= K_SYN;
      cal_mode_q <= 1'b0;
      auto_sel_q <= 1'b0;
      auto_q     <= 1'b0;
      cal_ok_q   <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      chan_q     <= CH_W'(1);
      pwr_q      <= '0;
      tbl_q      <= '0;
      cfg_q      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cmd_cal) begin
            cal_mode_q <= 1'b1;
            chan_q     <= CH_W'(1);
            tbl_q      <= '0;
            auto_sel_q <= 1'b0;
            step_q     <= K_SYN;
            state_q    <= S_EMIT;
          end else if (cmd_tune) begin
            if (!chan_ok || !cal_ok_q) begin
              err_q <= 1'b1;
            end else begin
              cal_mode_q <= 1'b0;
              chan_q     <= cmd_chan;
              pwr_q      <= cmd_pwr;
              tbl_q      <= cfg_q;
              auto_sel_q <= auto_q;
              step_q     <= K_SYN;
              state_q    <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          if (wr_ready) begin
            case (step_q)
              K_SYN: step_q <= K_DIV;
              K_DIV: step_q <= K_VCO;
              K_VCO: begin
                if (!cal_mode_q) begin
                  step_q <= K_M0;
                end else if (auto_sel_q) begin
                  auto_q   <= 1'b1;
                  cal_ok_q <= 1'b1;
                  state_q  <= S_IDLE;
                  done_q   <= 1'b1;
                end else begin
                  state_q <= S_ACK;
                end
              end
              K_M0: step_q <= K_M1;
              K_M1: step_q <= K_M2;
              K_M2: step_q <= K_M3;
              K_M3: begin
                if (gain_ok) begin
                  step_q <= K_GAIN;
                end else begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
                end
              end
              default: begin
                state_q <= S_IDLE;
                done_q  <= 1'b1;
              end
            endcase
          end
        end
        S_ACK: state_q <= S_RD;
        S_RD:  state_q <= S_CHK;
        S_CHK: begin
          if (locked) begin
            cfg_q    <= tbl_q + 1'b1;
            auto_q   <= 1'b0;
            cal_ok_q <= 1'b1;
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
          end else if (tbl_q == LAST_TRY) begin
            auto_sel_q <= 1'b1;
            step_q     <= K_SYN;
            state_q    <= S_EMIT;
          end else begin
            tbl_q   <= tbl_q + 1'b1;
            step_q  <= K_SYN;
            state_q <= S_EMIT;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign step           = step_q;
  assign chan           = chan_q;
  assign tbl            = tbl_q;
  assign use_auto       = auto_sel_q;
  assign pwr            = pwr_q;
  assign wr_valid       = state_q == S_EMIT;
  assign st_wr_en       = state_q == S_ACK;
  assign st_rd_en       = state_q == S_RD;
  assign busy           = state_q != S_IDLE;
  assign done           = done_q;
  assign err            = err_q;
  assign autocal_active = auto_q;

endmodule

// File: rtl/rf_tune_seq.sv
module rf_tune_seq
  import rts_pkg::*;
#(
  parameter int N_CFG    = 11,
  parameter int CHAN_MAX = 14,
  parameter int GAIN_N   = 19,
  parameter int CH_W     = 4,
  parameter int PWR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cal,
  input  logic              cmd_tune,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [PWR_W-1:0]  cmd_pwr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [23:0]       wr_word,
  output logic              st_wr_en,
  output logic [15:0]       st_wdata,
  output logic              st_rd_en,
  input  logic [15:0]       st_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              autocal_active
);

  localparam int TBL_W = $clog2(N_CFG);

  step_t            step;
  logic [CH_W-1:0]  chan;
  logic [TBL_W-1:0] tbl;
  logic             use_auto;
  logic [PWR_W-1:0] pwr;

  rts_fsm #(
    .N_CFG(N_CFG), .CHAN_MAX(CHAN_MAX), .GAIN_N(GAIN_N),
    .CH_W(CH_W), .PWR_W(PWR_W), .TBL_W(TBL_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_cal(cmd_cal), .cmd_tune(cmd_tune), .cmd_chan(cmd_chan), .cmd_pwr(cmd_pwr),
    .wr_ready(wr_ready), .st_rdata(st_rdata),
    .step(step), .chan(chan), .tbl(tbl), .use_auto(use_auto), .pwr(pwr),
    .wr_valid(wr_valid), .st_wr_en(st_wr_en), .st_rd_en(st_rd_en),
    .busy(busy), .done(done), .err(err), .autocal_active(autocal_active)
  );

  rts_word_gen #(.CH_W(CH_W), .TBL_W(TBL_W), .PWR_W(PWR_W)) u_gen (
    .step(step), .chan(chan), .tbl(tbl), .use_auto(use_auto), .pwr(pwr),
    .word(wr_word)
  );

  assign st_wdata = ST_ACK;

endmodule

// File: rtl/rf_tune_seq_chk.sv
module rf_tune_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [23:0] wr_word,
  input logic        st_wr_en,
  input logic        st_rd_en,
  input logic        busy,
  input logic        done,
  input logic        err
);

  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_word[23:20] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd7})); // R1

  AST_VCO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_word[23:20] == 4'd3) |-> wr_word[19:16] == 4'h4); // R3

  AST_READ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> (st_rd_en && !st_wr_en && !wr_valid)); // R4

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !wr_valid)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_valid && !st_wr_en && !st_rd_en)); // R10

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_word))); // R11

endmodule

bind rf_tune_seq rf_tune_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_word(wr_word), .st_wr_en(st_wr_en), .st_rd_en(st_rd_en),
  .busy(busy), .done(done), .err(err)
);

// File: tb/sim_rf_tune_seq.sv
module sim_rf_tune_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_cal = 1'b0, cmd_tune = 1'b0;
  logic [3:0]  cmd_chan = 4'd0;
  logic [4:0]  cmd_pwr = 5'd0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [23:0] wr_word;
  logic        st_wr_en, st_rd_en;
  logic [15:0] st_wdata;
  logic [15:0] st_rdata = 16'h0003;
  logic        busy, done, err, autocal_active;

  always #4 clk = ~clk;

  rf_tune_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_cal(cmd_cal), .cmd_tune(cmd_tune),
    .cmd_chan(cmd_chan), .cmd_pwr(cmd_pwr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_word(wr_word), .st_wr_en(st_wr_en), .st_wdata(st_wdata), .st_rd_en(st_rd_en),
    .st_rdata(st_rdata), .busy(busy), .done(done), .err(err),
    .autocal_active(autocal_active)
  );

  int checks = 0, errors = 0;
  logic [23:0] log_w [0:511];
  int nlog = 0, vco_cnt = 0, lock_at = 99, ack_cnt = 0, rd_cnt = 0, ack_bad = 0, cyc = 0;
  bit stall = 1'b0;

  // transfer log and lock-status register model, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (nlog < 512) log_w[nlog] = wr_word;
      nlog++;
      if (wr_word[23:20] == 4'd3) vco_cnt++;
    end
    if (st_wr_en) begin
      ack_cnt++;
      if (st_wdata !== 16'h000F) ack_bad++;
    end
    if (st_rd_en) begin
      rd_cnt++;
      st_rdata = (vco_cnt - 1 == lock_at) ? 16'h0000 : 16'h0003;
    end
  end

  always @(posedge clk) begin
    #2;
    cyc++;
    wr_ready = stall ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input bit cal, input logic [3:0] ch, input logic [4:0] pw);
    @(posedge clk); #2;
    cmd_cal = cal; cmd_tune = !cal; cmd_chan = ch; cmd_pwr = pw;
    @(posedge clk); #2;
    cmd_cal = 1'b0; cmd_tune = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R10 done seen"}, {31'd0, done}, 32'd1);
    chk({tag, " R10 busy low at done"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk({tag, " R10 done single"}, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset valid", {31'd0, wr_valid}, 32'd0);
    chk("R10 reset strobes", {30'd0, st_wr_en, st_rd_en}, 32'd0);
    chk("R9 reset err", {31'd0, err}, 32'd0);
    chk("R6 reset autocal", {31'd0, autocal_active}, 32'd0);
  endtask

  task automatic t_reject(input logic [3:0] ch, input string tag);
    int base = nlog;
    send(1'b0, ch, 5'd0);
    @(negedge clk);
    chk({tag, " R9 err pulse"}, {31'd0, err}, 32'd1);
    chk({tag, " R9 busy stays low"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk({tag, " R9 err one cycle"}, {31'd0, err}, 32'd0);
    repeat (6) @(negedge clk);
    chk({tag, " R9 no words"}, nlog - base, 32'd0);
  endtask

  task automatic t_cal(input int lk, input int tries, input bit auto_exp,
                       input logic [23:0] first_vco, input logic [23:0] last_vco,
                       input string tag);
    int base = nlog;
    int a0 = ack_cnt;
    int r0 = rd_cnt;
    lock_at = lk;
    vco_cnt = 0;
    send(1'b1, 4'd0, 5'd0);
    @(negedge clk);
    chk({tag, " R10 busy after cmd"}, {31'd0, busy}, 32'd1);
    wait_done(tag);
    repeat (4) @(negedge clk);
    chk({tag, " R5 word count"}, nlog - base, tries * 3 + (auto_exp ? 3 : 0));
    chk({tag, " R4 ack writes"}, ack_cnt - a0, tries);
    chk({tag, " R4 status reads"}, rd_cnt - r0, tries);
    chk({tag, " R4 ack value"}, ack_bad, 32'd0);
    for (int i = 0; i < tries; i++) begin
      chk({tag, " R1 R2 synth ch1"}, log_w[base + 3*i], 24'h100047);
      chk({tag, " R2 divide ch1"}, log_w[base + 3*i + 1], 24'h200999);
    end
    chk({tag, " R3 R5 first vco"}, log_w[base + 2], first_vco);
    chk({tag, " R3 R5 last vco"}, log_w[base + 3*tries - 1], last_vco);
    if (auto_exp) begin
      chk({tag, " R6 auto synth"}, log_w[base + 3*tries], 24'h106847);
      chk({tag, " R6 auto divide"}, log_w[base + 3*tries + 1], 24'h200999);
      chk({tag, " R6 auto vco"}, log_w[base + 3*tries + 2], 24'h346662);
    end
    chk({tag, " R6 autocal flag"}, {31'd0, autocal_active}, {31'd0, auto_exp});
  endtask

  task automatic t_tune(input logic [3:0] ch, input logic [4:0] pw,
                        input logic [23:0] e_syn, input logic [23:0] e_div,
                        input logic [23:0] e_vco, input logic [23:0] e_gain,
                        input bit has_gain, input bit stall_v, input string tag);
    int base = nlog;
    stall = stall_v;
    send(1'b0, ch, pw);
    @(negedge clk);
    chk({tag, " R10 busy after cmd"}, {31'd0, busy}, 32'd1);
    // calibration request while busy must be ignored
    @(posedge clk); #2; cmd_cal = 1'b1;
    @(posedge clk); #2; cmd_cal = 1'b0;
    wait_done(tag);
    repeat (10) @(negedge clk);
    chk({tag, " R10 busy-time cmd ignored"}, {31'd0, busy}, 32'd0);
    chk({tag, " R7 R8 R11 word count"}, nlog - base, has_gain ? 32'd8 : 32'd7);
    chk({tag, " R1 R2 synth"}, log_w[base], e_syn);
    chk({tag, " R2 divide"}, log_w[base + 1], e_div);
    chk({tag, " R3 vco"}, log_w[base + 2], e_vco);
    chk({tag, " R7 mode a"}, log_w[base + 3], 24'h025F98);
    chk({tag, " R7 mode b"}, log_w[base + 4], 24'h025F9A);
    chk({tag, " R7 mode c"}, log_w[base + 5], 24'h025F94);
    chk({tag, " R7 mode d"}, log_w[base + 6], 24'h027FD4);
    if (has_gain) chk({tag, " R8 gain"}, log_w[base + 7], e_gain);
    stall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reject(4'd5, "tune-before-cal");
    t_cal(2, 3, 1'b0, 24'h34664D, 24'h34665D, "cal-lock2");
    t_tune(4'd5, 5'd4, 24'h100067, 24'h200999, 24'h34665D, 24'h70EA93, 1'b1, 1'b1, "ch5");
    t_tune(4'd14, 5'd19, 24'h10004F, 24'h200CCC, 24'h34664D, 24'h0, 1'b0, 1'b0, "ch14-nogain");
    t_reject(4'd0, "chan0");
    t_reject(4'd15, "chan15");
    t_tune(4'd2, 5'd18, 24'h100047, 24'h20099B, 24'h34667D, 24'h73FFFF, 1'b1, 1'b1, "ch2");
    t_cal(0, 1, 1'b0, 24'h34664D, 24'h34664D, "cal-lock0");
    t_tune(4'd7, 5'd0, 24'h100057, 24'h200998, 24'h34644D, 24'h70E313, 1'b1, 1'b0, "ch7");
    t_cal(99, 10, 1'b1, 24'h34664D, 24'h34666B, "cal-nolock");
    t_tune(4'd11, 5'd5, 24'h106877, 24'h200998, 24'h346662, 24'h71F093, 1'b1, 1'b1, "ch11-auto");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule